// File: doc/BRIEF.md
# Elastic Sample Buffer with Collision Mute

This block is a dual-clock elastic buffer that sits in front of a filter stage and holds stereo audio samples until the filter consumes them. The input side stores one left/right pair on every input word-clock edge where a write is requested. The output side hands the oldest stored pair to the filter one read clock after a read request. The write pointer reaches the read side as a Gray-coded value through a two-flop synchroniser. All supervision happens in the read domain.

A mode pin selects how far the write side may run ahead of the reader. The shallow setting keeps the delay low. The deep setting tolerates larger swings in the sample-rate ratio. When the pointers collide, the block treats it as a slip. The collision is either an overflow, where the writer is too far ahead, or an underflow, where a read finds nothing stored. On a slip the block moves the read pointer back to the middle of the selected depth and raises a mute flag for a fixed number of read clocks. A separate mute input forces the data outputs to zero. In normal use this input is wired to the mute flag, so a slip silences the output by itself.

Top module: `elastic_mute_fifo`

## Requirements
- R1: Under reset, both data outputs are zero and the mute flag is low.
- R2: Each read request returns on the next read clock the left and right samples stored by one write, in write order. A write becomes visible to the read side on the second read-clock edge after the write commits.
- R3: A slip occurs when the visible occupancy exceeds the selected depth. The depth is 16 with the mode pin low and 64 with it high. An occupancy equal to the depth is not a slip.
- R4: A read request made while the visible occupancy is zero is an underflow slip. The read is not performed.
- R5: On any slip, the read pointer is set to half the selected depth (8 or 32) behind the visible write pointer. Reads that follow return the samples from that point on.
- R6: A slip drives the mute flag high for exactly 128 read clocks, starting on the edge where the slip is detected.
- R7: A slip while the mute flag is high restarts the 128-clock count.
- R8: A change of the mode pin, once seen after its two-flop synchroniser, counts as a slip and re-centres the pointer using the new depth.
- R9: While the mute input is high, every bit of both data outputs is zero. The mute input does not change stored data or pointers.
- R10: The data outputs hold their value on read clocks with no read request, and on read clocks where a slip is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Input word clock (write side) |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_en | input | 1 | Store the current stereo pair on this wclk edge |
| wr_left | input | 16 | Left sample to store |
| wr_right | input | 16 | Right sample to store |
| rclk | input | 1 | Output processing clock (read side) |
| rd_en | input | 1 | Request the next stored pair |
| deep_mode | input | 1 | 0 selects depth 16, 1 selects depth 64 |
| mute_i | input | 1 | Forces the data outputs to zero while high |
| rd_left | output | 16 | Left sample delivered to the filter |
| rd_right | output | 16 | Right sample delivered to the filter |
| mute_o | output | 1 | High for 128 read clocks after a slip |

## Verification
Read data and the mute flag are due on the read-clock edge after the request or slip. A write affects slip detection two read edges after it commits, and a mode change three read edges after the pin moves. The bench places the two clocks half a read period apart, so these latencies are exact. Its behavioural model advances a delayed write count and mode on every read edge. It compares the outputs with the model two nanoseconds after each read edge, once they have settled. Explicit checks measure the mute pulse width, both for a single slip and for a restarted pulse.

// File: rtl/elastic_mute_fifo.sv
module elastic_mute_fifo #(
  parameter int SW          = 16,
  parameter int SHALLOW     = 16,
  parameter int DEEP        = 64,
  parameter int MUTE_CYCLES = 128
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_left,
  input  logic [SW-1:0] wr_right,
  input  logic          rclk,
  input  logic          rd_en,
  input  logic          deep_mode,
  input  logic          mute_i,
  output logic [SW-1:0] rd_left,
  output logic [SW-1:0] rd_right,
  output logic          mute_o
);
  localparam int AW = $clog2(DEEP);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(MUTE_CYCLES + 1);
  localparam logic [PW-1:0] LIM_S = PW'(SHALLOW);
  localparam logic [PW-1:0] LIM_D = PW'(DEEP);
  localparam logic [CW-1:0] MUTE_LOAD = CW'(MUTE_CYCLES);

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write side
  logic [2*SW-1:0] mem [DEEP];
  logic [PW-1:0]   wbin, wgray, wnext;

  assign wnext = wbin + 1'b1;

  always_ff @(posedge wclk or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      wbin  <= wnext;
      wgray <= wnext ^ (wnext >> 1);
    end

  always_ff @(posedge wclk)
    if (wr_en) mem[wbin[AW-1:0]] <= {wr_left, wr_right};

  // read side
  logic [PW-1:0]   wg_s1, wg_s2, wvis, rptr, occ, lim, half;
  logic            m_s1, m_s2, m_app, mode_chg, coll;
  logic [CW-1:0]   mcnt;
  logic [2*SW-1:0] dq;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      wg_s1 <= '0;
      wg_s2 <= '0;
      m_s1  <= 1'b0;
      m_s2  <= 1'b0;
      m_app <= 1'b0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      m_s1  <= deep_mode;
      m_s2  <= m_s1;
      m_app <= m_s2;
    end

  assign wvis     = gray2bin(wg_s2);
  assign occ      = wvis - rptr;
  assign lim      = m_s2 ? LIM_D : LIM_S;
  assign half     = lim >> 1;
  assign mode_chg = m_s2 != m_app;
  assign coll     = mode_chg | (occ > lim) | (rd_en & (occ == '0));

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) begin
      rptr <= '0;
      mcnt <= '0;
      dq   <= '0;
    end else if (coll) begin
      rptr <= wvis - half;
      mcnt <= MUTE_LOAD;
    end else begin
      if (rd_en) begin
        dq   <= mem[rptr[AW-1:0]];
        rptr <= rptr + 1'b1;
      end
      if (mcnt != '0) mcnt <= mcnt - 1'b1;
    end

  assign mute_o   = mcnt != '0;
  assign rd_left  = mute_i ? '0 : dq[2*SW-1:SW];
  assign rd_right = mute_i ? '0 : dq[SW-1:0];
endmodule

// File: rtl/elastic_mute_fifo_chk.sv
module elastic_mute_fifo_chk #(
  parameter int SW          = 16,
  parameter int PW          = 7,
  parameter int MUTE_CYCLES = 128
) (
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          mute_o,
  input logic          coll,
  input logic [PW-1:0] occ,
  input logic [PW-1:0] lim,
  input logic [2*SW-1:0] dq
);
  logic [15:0] run_q;

  always_ff @(posedge rclk or negedge rst_n)
    if (!rst_n) run_q <= '0;
    else if (!mute_o) run_q <= '0;
    else if (run_q != 16'hFFFF) run_q <= run_q + 1'b1;

  a_r3_overflow_mutes: assert property (@(posedge rclk) disable iff (!rst_n)
    (occ > lim) |=> mute_o);

  a_r4_underflow_mutes: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && occ == '0) |=> mute_o);

  a_r5_recentred: assert property (@(posedge rclk) disable iff (!rst_n)
    coll |=> ((occ - (lim >> 1)) <= PW'(1)));

  a_r6_pulse_length: assert property (@(posedge rclk) disable iff (!rst_n)
    $fell(mute_o) |-> (run_q >= 16'(MUTE_CYCLES)));

  a_r10_hold_idle: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_en |=> $stable(dq));

  a_r10_hold_slip: assert property (@(posedge rclk) disable iff (!rst_n)
    coll |=> $stable(dq));
endmodule

bind elastic_mute_fifo elastic_mute_fifo_chk u_chk (
  .rclk(rclk), .rst_n(rst_n), .rd_en(rd_en), .mute_o(mute_o),
  .coll(coll), .occ(occ), .lim(lim), .dq(dq)
);

// File: tb/tb_elastic_mute_fifo.sv
module tb_elastic_mute_fifo;
  localparam int RCLK_PERIOD = 10;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, deep_mode = 0, force_mute = 0, loop_en = 0;
  logic [15:0] wr_left, wr_right, rd_left, rd_right;
  logic mute_o, mute_i;
  int wtotal = 0;
  int checks = 0, fails = 0;
  int run = 0, last_run = 0;
  bit done = 0;
  string cur_req = "R2";

  initial forever #(RCLK_PERIOD/2) rclk = ~rclk;
  initial begin #(RCLK_PERIOD); forever #(RCLK_PERIOD) wclk = ~wclk; end

  function automatic logic [15:0] fl(int n); return 16'(n * 3 + 1); endfunction
  function automatic logic [15:0] fr(int n); return 16'(n ^ 32'h5A5A); endfunction

  assign wr_left  = fl(wtotal);
  assign wr_right = fr(wtotal);
  assign mute_i   = loop_en ? mute_o : force_mute;

  elastic_mute_fifo dut (
    .wclk(wclk), .rst_n(rst_n), .wr_en(wr_en), .wr_left(wr_left), .wr_right(wr_right),
    .rclk(rclk), .rd_en(rd_en), .deep_mode(deep_mode), .mute_i(mute_i),
    .rd_left(rd_left), .rd_right(rd_right), .mute_o(mute_o)
  );

  always @(posedge wclk) if (wr_en) wtotal <= wtotal + 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference: delayed write count and mode, integer read position
  int m_rp = 0, q1 = 0, q2 = 0, m_cnt = 0;
  bit mq1 = 0, mq2 = 0, mq3 = 0, known = 1;
  logic [15:0] el = 0, er = 0;

  always @(posedge rclk) begin
    int wv, occ, dep, r, n;
    bit ms, mchg, slip;
    if (!rst_n) begin
      m_rp = 0; q1 = 0; q2 = 0; m_cnt = 0; mq1 = 0; mq2 = 0; mq3 = 0;
      known = 1; el = 0; er = 0;
    end else begin
      wv = q2; q2 = q1; q1 = wtotal;
      ms = mq2; mchg = (mq2 != mq3); mq3 = mq2; mq2 = mq1; mq1 = deep_mode;
      dep = ms ? 64 : 16;
      occ = wv - m_rp;
      slip = mchg || (occ > dep) || (rd_en && occ == 0);
      if (slip) begin
        m_rp = wv - dep / 2;
        m_cnt = 128;
      end else begin
        if (rd_en) begin
          r = ((m_rp % 64) + 64) % 64;
          if (r >= wtotal) known = 0;
          else begin
            n = r + 64 * ((wtotal - 1 - r) / 64);
            el = fl(n); er = fr(n); known = 1;
          end
          m_rp++;
        end
        if (m_cnt > 0) m_cnt--;
      end
    end
  end

  always @(posedge rclk) begin
    bit em, mi;
    #2;
    if (rst_n && !done) begin
      em = (m_cnt != 0);
      chk(cur_req, "mute_o", int'(mute_o), int'(em));
      mi = loop_en ? em : force_mute;
      if (mi) begin
        chk("R9", "rd_left muted", int'(rd_left), 0);
        chk("R9", "rd_right muted", int'(rd_right), 0);
      end else if (known) begin
        chk(cur_req, "rd_left", int'(rd_left), int'(el));
        chk(cur_req, "rd_right", int'(rd_right), int'(er));
      end
      if (mute_o) run++;
      else begin
        if (run > 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic wr_burst(int n);
    repeat (n) begin @(negedge wclk); wr_en = 1; end
    @(negedge wclk); wr_en = 0;
  endtask

  task automatic rd_burst(int n);
    repeat (n) begin @(negedge rclk); rd_en = 1; end
    @(negedge rclk); rd_en = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(RCLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-R10 stalled: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    #(2 * RCLK_PERIOD);
    // R1: reset values, checked before release
    chk("R1", "mute_o in reset", int'(mute_o), 0);
    chk("R1", "rd_left in reset", int'(rd_left), 0);
    chk("R1", "rd_right in reset", int'(rd_right), 0);
    rst_n = 1;

    // R2: in-order delivery
    cur_req = "R2";
    wr_burst(10); idle(6); rd_burst(10); idle(3);
    chk("R2", "last left", int'(rd_left), int'(fl(9)));
    chk("R2", "last right", int'(rd_right), int'(fr(9)));
    cur_req = "R10";
    idle(5);
    chk("R10", "held left", int'(rd_left), int'(fl(9)));
    chk("R10", "no slip", int'(mute_o), 0);

    // R4 + R6: underflow and pulse width
    cur_req = "R4";
    rd_burst(1); idle(2);
    chk("R4", "underflow mute", int'(mute_o), 1);
    cur_req = "R6";
    idle(140);
    chk("R6", "mute pulse width", last_run, 128);

    // R5: reads resume 8 behind write pointer (index 2)
    cur_req = "R5";
    rd_burst(5); idle(2);
    chk("R5", "recentred left", int'(rd_left), int'(fl(6)));
    rd_burst(3); idle(2);

    // R9: mute input zeroes outputs without touching state
    cur_req = "R9";
    wr_burst(4); idle(6);
    force_mute = 1;
    rd_burst(2); idle(2);
    chk("R9", "forced left", int'(rd_left), 0);
    chk("R9", "forced right", int'(rd_right), 0);
    force_mute = 0;
    idle(1);
    chk("R9", "unmuted left", int'(rd_left), int'(fl(11)));
    rd_burst(2); idle(2);

    // R3 shallow: overflow at 17 with mute looped back
    cur_req = "R3";
    loop_en = 1;
    wr_burst(20); idle(6);
    chk("R3", "overflow mute", int'(mute_o), 1);
    chk("R3", "looped silence", int'(rd_left), 0);
    idle(130);
    loop_en = 0;
    rd_burst(11); idle(2);
    chk("R5", "after overflow left", int'(rd_left), int'(fl(33)));

    // R7: second underflow inside the pulse restarts it
    cur_req = "R7";
    rd_burst(10); idle(140);
    chk("R7", "restarted pulse width", last_run, 137);
    rd_burst(8); idle(2);

    // R8: switch to deep depth
    cur_req = "R8";
    @(negedge rclk); deep_mode = 1;
    idle(4);
    chk("R8", "mode change mute", int'(mute_o), 1);
    idle(130);
    rd_burst(5); idle(2);
    chk("R8", "deep recentre left", int'(rd_left), int'(fl(6)));

    // R3 deep boundary: 64 is fine, 65 slips
    cur_req = "R3";
    wr_burst(37); idle(6);
    chk("R3", "occupancy 64 no slip", int'(mute_o), 0);
    wr_burst(1); idle(6);
    chk("R3", "occupancy 65 slip", int'(mute_o), 1);
    idle(130);
    rd_burst(32); idle(2);
    chk("R3", "deep data left", int'(rd_left), int'(fl(71)));

    // R8: back to shallow, re-centred 8 behind
    cur_req = "R8";
    @(negedge rclk); deep_mode = 0;
    idle(140);
    rd_burst(4); idle(2);
    chk("R8", "shallow recentre left", int'(rd_left), int'(fl(67)));
    chk("R8", "shallow recentre right", int'(rd_right), int'(fr(67)));

    idle(3);
    finish_run();
  end
endmodule